// File: doc/BRIEF.md
# DMA Channel Three-Level Address Generator

This block produces the read and write addresses for a single DMA channel. A transfer is built from bursts, and a burst is built from 16-bit words. The block walks a source pointer and a destination pointer through that nesting. Inside a burst, each pointer moves by its burst step after every word. Between bursts, it moves by its transfer step. A per-side wrap counter can take over at burst boundaries instead: when it runs out, the pointer jumps to a base address, and that base moves on by a signed wrap step.

The data mover sends one `wordDone` strobe for each word it has moved. The generator answers with the next address pair and raises `burstDone` and `xferDone` on the final words. An external sync pulse reloads one side's wrap counter, which keeps a wrap pattern aligned with a periodic producer such as a sequenced converter. In 32-bit data mode the block is unchanged: software writes the burst length and all steps at twice their word values.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset both addresses read 0, both flags are low, and the block is idle.
- R2: A `start` pulse while idle loads both pointers and both wrap bases from `srcBegin`/`dstBegin`, and the block becomes busy on the next edge. A `start` while busy is ignored.
- R3: Inside a burst, each accepted `wordDone` that is not the burst's last word adds that side's burst step to the pointer. Steps are 13-bit two's complement (-4096..4095), sign-extended, and the sum wraps modulo 2^22. A step of 0 holds the pointer.
- R4: At the end of a burst that is not the last burst and does not wrap, the pointer moves by the transfer step instead of the burst step, and the wrap counter decrements by one.
- R5: At the end of a burst that is not the last burst, if the side's wrap counter is 0, the base becomes base+wrapStep, the pointer loads that new base, and the counter reloads the wrap-size field. The transfer step is not used in that case. A wrap-size field W therefore wraps after every W+1 bursts.
- R6: When a side's wrap-size field is at least `xferLen`, that side never wraps, and its sequence depends only on its burst and transfer steps.
- R7: `burstLen` holds words-per-burst minus 1 (1..32 words). `xferLen` holds bursts-per-transfer minus 1 (1..65536 bursts).
- R8: `burstDone` is high, combinationally, in exactly those cycles in which `wordDone` is accepted for the last word of a burst.
- R9: `xferDone` is high, combinationally, only with the last word of the last burst. The block is idle on the next edge, both addresses then hold, and later `wordDone` strobes change nothing.
- R10: While busy, a `syncPulse` with `syncEn`=1 reloads the destination wrap counter from its wrap-size field when `syncDstSel`=1, and the source counter when `syncDstSel`=0. With `syncEn`=0 a sync pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (used only when idle) |
| wordDone | input | 1 | One word moved by the data mover |
| syncPulse | input | 1 | External wrap-counter sync |
| syncEn | input | 1 | Enables sync handling |
| syncDstSel | input | 1 | 1: sync reloads destination counter, 0: source |
| burstLen | input | 5 | Words per burst minus 1 |
| xferLen | input | 16 | Bursts per transfer minus 1 |
| srcBegin | input | 22 | Source start/base address |
| srcBurstStep | input | 13 | Signed source step inside a burst |
| srcXferStep | input | 13 | Signed source step between bursts |
| srcWrapSize | input | 16 | Source bursts between wraps minus 1 |
| srcWrapStep | input | 13 | Signed source base advance per wrap |
| dstBegin | input | 22 | Destination start/base address |
| dstBurstStep | input | 13 | Signed destination step inside a burst |
| dstXferStep | input | 13 | Signed destination step between bursts |
| dstWrapSize | input | 16 | Destination bursts between wraps minus 1 |
| dstWrapStep | input | 13 | Signed destination base advance per wrap |
| srcAddr | output | 22 | Current source address |
| dstAddr | output | 22 | Current destination address |
| burstDone | output | 1 | Last word of a burst accepted |
| xferDone | output | 1 | Last word of the transfer accepted |

## Verification
The assertions check on every cycle the properties that hold locally. Addresses stay still in any cycle without an accepted word. A mid-burst word moves each pointer by its signed burst step. `burstDone` only accompanies an accepted strobe, `xferDone` only accompanies `burstDone`, and the block is idle right after `xferDone`. Only the bench scenarios can show the full sequences over many bursts. These are the choice between transfer step and wrap, the base drifting by the wrap step, wrap disabled by a large wrap size, sync reloads that delay a wrap on the selected side only, and a start pulse ignored in mid-transfer.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef struct packed {
    logic load;       // start accepted: load pointers, bases, counters
    logic wordStep;   // word accepted, not last in burst
    logic burstEnd;   // word accepted, last in burst
    logic lastBurst;  // current burst is the final one
  } agStrobes_t;
endpackage

// File: rtl/dma_ag_ctrl.sv
module dma_ag_ctrl
  import dma_ag_pkg::*;
#(
  parameter int BURST_W = 5,
  parameter int XFER_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               wordDone,
  input  logic [BURST_W-1:0] burstLen,
  input  logic [XFER_W-1:0]  xferLen,
  output agStrobes_t         stb,
  output logic               busy
);
  logic [BURST_W-1:0] wordCnt;
  logic [XFER_W-1:0]  burstCnt;

  always_comb begin
    stb.load      = start & ~busy;
    stb.lastBurst = (burstCnt == '0);
    stb.wordStep  = busy & wordDone & (wordCnt != '0);
    stb.burstEnd  = busy & wordDone & (wordCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      wordCnt  <= '0;
      burstCnt <= '0;
    end else if (stb.load) begin
      busy     <= 1'b1;
      wordCnt  <= burstLen;
      burstCnt <= xferLen;
    end else if (stb.wordStep) begin
      wordCnt <= wordCnt - 1'b1;
    end else if (stb.burstEnd) begin
      wordCnt <= burstLen;
      if (stb.lastBurst) busy <= 1'b0;
      else               burstCnt <= burstCnt - 1'b1;
    end
  end
endmodule

// File: rtl/dma_ag_side.sv
module dma_ag_side
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int STEP_W = 13,
  parameter int WRAP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  agStrobes_t        stb,
  input  logic              syncHit,
  input  logic [ADDR_W-1:0] beginAddr,
  input  logic [STEP_W-1:0] burstStep,
  input  logic [STEP_W-1:0] xferStep,
  input  logic [WRAP_W-1:0] wrapSize,
  input  logic [STEP_W-1:0] wrapStep,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - STEP_W;

  logic [ADDR_W-1:0] baseReg;
  logic [WRAP_W-1:0] wrapCnt;
  logic [ADDR_W-1:0] burstExt, xferExt, wrapExt, baseNext;

  assign burstExt = {{EXT_W{burstStep[STEP_W-1]}}, burstStep};
  assign xferExt  = {{EXT_W{xferStep[STEP_W-1]}},  xferStep};
  assign wrapExt  = {{EXT_W{wrapStep[STEP_W-1]}},  wrapStep};
  assign baseNext = baseReg + wrapExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      baseReg <= '0;
      wrapCnt <= '0;
    end else if (stb.load) begin
      addr    <= beginAddr;
      baseReg <= beginAddr;
      wrapCnt <= wrapSize;
    end else begin
      if (stb.wordStep) addr <= addr + burstExt;
      if (stb.burstEnd && !stb.lastBurst) begin
        if (wrapCnt == '0) begin
          baseReg <= baseNext;
          addr    <= baseNext;
          wrapCnt <= wrapSize;
        end else begin
          addr    <= addr + xferExt;
          wrapCnt <= wrapCnt - 1'b1;
        end
      end
      if (syncHit) wrapCnt <= wrapSize;
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int STEP_W  = 13,
  parameter int BURST_W = 5,
  parameter int XFER_W  = 16,
  parameter int WRAP_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               wordDone,
  input  logic               syncPulse,
  input  logic               syncEn,
  input  logic               syncDstSel,
  input  logic [BURST_W-1:0] burstLen,
  input  logic [XFER_W-1:0]  xferLen,
  input  logic [ADDR_W-1:0]  srcBegin,
  input  logic [STEP_W-1:0]  srcBurstStep,
  input  logic [STEP_W-1:0]  srcXferStep,
  input  logic [WRAP_W-1:0]  srcWrapSize,
  input  logic [STEP_W-1:0]  srcWrapStep,
  input  logic [ADDR_W-1:0]  dstBegin,
  input  logic [STEP_W-1:0]  dstBurstStep,
  input  logic [STEP_W-1:0]  dstXferStep,
  input  logic [WRAP_W-1:0]  dstWrapSize,
  input  logic [STEP_W-1:0]  dstWrapStep,
  output logic [ADDR_W-1:0]  srcAddr,
  output logic [ADDR_W-1:0]  dstAddr,
  output logic               burstDone,
  output logic               xferDone
);
  agStrobes_t stb;
  logic       busy;
  logic       syncLive;

  dma_ag_ctrl #(.BURST_W(BURST_W), .XFER_W(XFER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wordDone(wordDone),
    .burstLen(burstLen), .xferLen(xferLen), .stb(stb), .busy(busy)
  );

  assign syncLive = busy & syncEn & syncPulse;

  dma_ag_side #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .WRAP_W(WRAP_W)) u_src (
    .clk(clk), .rstN(rstN), .stb(stb), .syncHit(syncLive & ~syncDstSel),
    .beginAddr(srcBegin), .burstStep(srcBurstStep), .xferStep(srcXferStep),
    .wrapSize(srcWrapSize), .wrapStep(srcWrapStep), .addr(srcAddr)
  );

  dma_ag_side #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .WRAP_W(WRAP_W)) u_dst (
    .clk(clk), .rstN(rstN), .stb(stb), .syncHit(syncLive & syncDstSel),
    .beginAddr(dstBegin), .burstStep(dstBurstStep), .xferStep(dstXferStep),
    .wrapSize(dstWrapSize), .wrapStep(dstWrapStep), .addr(dstAddr)
  );

  assign burstDone = stb.burstEnd;
  assign xferDone  = stb.burstEnd & stb.lastBurst;
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int ADDR_W = 22,
  parameter int STEP_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              wordDone,
  input logic              busy,
  input logic              burstDone,
  input logic              xferDone,
  input logic [STEP_W-1:0] srcBurstStep,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] dstAddr
);
  localparam int EXT_W = ADDR_W - STEP_W;

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wordDone) |=> ($stable(srcAddr) && $stable(dstAddr)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(srcAddr) && $stable(dstAddr)));

  // R3
  burst_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wordDone && !burstDone) |=>
      (srcAddr == $past(srcAddr) + {{EXT_W{$past(srcBurstStep[STEP_W-1])}}, $past(srcBurstStep)}));

  // R8
  burst_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> (wordDone && busy));

  // R9
  xfer_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> burstDone);

  // R9
  xfer_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !busy);
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .wordDone(wordDone), .busy(busy),
  .burstDone(burstDone), .xferDone(xferDone), .srcBurstStep(srcBurstStep),
  .srcAddr(srcAddr), .dstAddr(dstAddr)
);

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 0, wordDone = 0, syncPulse = 0, syncEn = 0, syncDstSel = 0;
  logic [4:0]  burstLen = 0;
  logic [15:0] xferLen = 0;
  logic [21:0] srcBegin = 0, dstBegin = 0;
  logic [12:0] srcBurstStep = 0, srcXferStep = 0, srcWrapStep = 0;
  logic [12:0] dstBurstStep = 0, dstXferStep = 0, dstWrapStep = 0;
  logic [15:0] srcWrapSize = 0, dstWrapSize = 0;
  logic [21:0] srcAddr, dstAddr;
  logic        burstDone, xferDone;

  int total = 0;
  int bad = 0;
  int syncAt = -1;
  int restartAt = -1;

  always #4 clk = ~clk;

  dma_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .start(start), .wordDone(wordDone),
    .syncPulse(syncPulse), .syncEn(syncEn), .syncDstSel(syncDstSel),
    .burstLen(burstLen), .xferLen(xferLen),
    .srcBegin(srcBegin), .srcBurstStep(srcBurstStep), .srcXferStep(srcXferStep),
    .srcWrapSize(srcWrapSize), .srcWrapStep(srcWrapStep),
    .dstBegin(dstBegin), .dstBurstStep(dstBurstStep), .dstXferStep(dstXferStep),
    .dstWrapSize(dstWrapSize), .dstWrapStep(dstWrapStep),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .burstDone(burstDone), .xferDone(xferDone)
  );

  function automatic logic [21:0] sx(input logic [12:0] s);
    return {{9{s[12]}}, s};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Runs one transfer against a word-by-word model built from R3..R10.
  task automatic runXfer(input string req);
    logic [21:0] sa, da, sb, db;
    int swc, dwc, nb, bl;
    logic [21:0] svB, dvB;
    nb = int'(xferLen) + 1; bl = int'(burstLen) + 1;
    sb = srcBegin; db = dstBegin; sa = sb; da = db;
    swc = int'(srcWrapSize); dwc = int'(dstWrapSize);
    pulseStart();
    for (int b = 0; b < nb; b++) begin
      if (b == syncAt) begin
        wordDone = 1'b0; syncPulse = 1'b1;
        @(negedge clk); syncPulse = 1'b0;
        if (syncEn) begin
          if (syncDstSel) dwc = int'(dstWrapSize); else swc = int'(srcWrapSize);
        end
      end
      if (b == restartAt) begin
        wordDone = 1'b0; svB = srcBegin; dvB = dstBegin;
        srcBegin = 22'h2AAAAA; dstBegin = 22'h155555; start = 1'b1;
        @(negedge clk); start = 1'b0; srcBegin = svB; dstBegin = dvB;
      end
      for (int w = 0; w < bl; w++) begin
        wordDone = 1'b1;
        #1;
        chk(req, "srcAddr", 32'(srcAddr), 32'(sa));
        chk(req, "dstAddr", 32'(dstAddr), 32'(da));
        chk({req, " R8"}, "burstDone", 32'(burstDone), 32'(w == bl - 1));
        chk({req, " R9"}, "xferDone", 32'(xferDone), 32'((w == bl - 1) && (b == nb - 1)));
        @(negedge clk);
        if (w < bl - 1) begin
          sa = sa + sx(srcBurstStep); da = da + sx(dstBurstStep);
        end else if (b < nb - 1) begin
          if (swc == 0) begin sb = sb + sx(srcWrapStep); sa = sb; swc = int'(srcWrapSize); end
          else begin sa = sa + sx(srcXferStep); swc--; end
          if (dwc == 0) begin db = db + sx(dstWrapStep); da = db; dwc = int'(dstWrapSize); end
          else begin da = da + sx(dstXferStep); dwc--; end
        end
      end
    end
    wordDone = 1'b0;
    // R9: idle after the transfer, strobes ignored, addresses held
    repeat (2) begin
      @(negedge clk); wordDone = 1'b1; #1;
      chk("R9", "idle burstDone", 32'(burstDone), 32'd0);
      @(negedge clk); wordDone = 1'b0; #1;
      chk("R9", "idle srcAddr", 32'(srcAddr), 32'(sa));
      chk("R9", "idle dstAddr", 32'(dstAddr), 32'(da));
    end
    syncAt = -1; restartAt = -1;
  endtask

  task automatic setCfg(input int bw, input int nbm1,
                        input logic [21:0] sB, input int sbs, input int sxs, input int sws, input int swst,
                        input logic [21:0] dB, input int dbs, input int dxs, input int dws, input int dwst);
    burstLen = 5'(bw); xferLen = 16'(nbm1);
    srcBegin = sB; srcBurstStep = 13'(sbs); srcXferStep = 13'(sxs); srcWrapSize = 16'(sws); srcWrapStep = 13'(swst);
    dstBegin = dB; dstBurstStep = 13'(dbs); dstXferStep = 13'(dxs); dstWrapSize = 16'(dws); dstWrapStep = 13'(dwst);
  endtask

  task automatic testReset();
    #1;
    chk("R1", "srcAddr", 32'(srcAddr), 32'd0);
    chk("R1", "dstAddr", 32'(dstAddr), 32'd0);
    chk("R1", "burstDone", 32'(burstDone), 32'd0);
    chk("R1", "xferDone", 32'(xferDone), 32'd0);
  endtask

  task automatic testLinear();  // R2 R3 R4 R6 R7, dst crosses zero modulo 2^22
    setCfg(3, 2, 22'h000100, 1, 7, 100, 0, 22'h000002, -2, 5, 100, 0);
    runXfer("R2/R3/R4/R6/R7 linear");
  endtask

  task automatic testWrap();  // R5: src wraps every burst, dst every 2 bursts
    setCfg(1, 5, 22'h001000, 1, 1000, 0, 16, 22'h002000, 2, 3, 1, -8);
    runXfer("R5 wrap");
  endtask

  task automatic testHold();  // R3: zero steps, one word per burst
    setCfg(0, 3, 22'h3FFFFF, 0, 0, 9, 0, 22'h000123, 0, 0, 9, 0);
    runXfer("R3 hold");
  endtask

  task automatic testLongBurst();  // R7: 32 words, step extremes
    setCfg(31, 1, 22'h100000, 4095, -4096, 1, 3, 22'h200000, -4096, 4095, 0, -1);
    runXfer("R7 long");
  endtask

  task automatic testWrapOff();  // R6: wrap size equals xferLen
    setCfg(1, 3, 22'h000040, 2, 11, 3, 500, 22'h000080, -1, -3, 7, 500);
    runXfer("R6 nowrap");
  endtask

  task automatic testRestart();  // R2: start while busy ignored
    setCfg(2, 3, 22'h000500, 1, 1, 100, 0, 22'h000600, 1, 1, 100, 0);
    restartAt = 2;
    runXfer("R2 restart");
  endtask

  task automatic testSync();  // R10 three variants
    setCfg(0, 7, 22'h000010, 0, 4, 2, 100, 22'h000020, 0, 4, 2, 100);
    syncEn = 1'b1; syncDstSel = 1'b0; syncAt = 2;
    runXfer("R10 sync src");
    syncEn = 1'b1; syncDstSel = 1'b1; syncAt = 2;
    runXfer("R10 sync dst");
    syncEn = 1'b0; syncDstSel = 1'b0; syncAt = 2;
    runXfer("R10 sync off");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk); rstN = 1'b1;
    testLinear();
    testWrap();
    testHold();
    testLongBurst();
    testWrapOff();
    testRestart();
    testSync();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule